// File: doc/BRIEF.md
# SD/MMC Command Path Engine

This block drives the command line of an SD/MMC host. A register-style strobe loads a 6-bit command index, a 32-bit argument and a set of control flags. The engine then sends a 48-bit command frame with its CRC7 on the serial command line, one bit per clock. When the command expects a reply, it waits for the card's start bit. It then captures either a short (48-bit) or a long (136-bit) response, checks its CRC and reports the outcome as sticky status bits.

Two options change the flow. A pending option holds the frame back until an external pending input rises. A programming option makes the engine watch DAT0 after the command, and it signals completion when the card releases its busy level. Software-facing registers, clock division and the data path sit outside the block. Status bits stay set until a write-one-to-clear strobe removes them.

Top module: `sdcmd_engine`

## Requirements
- R1: A command is accepted only when `start` is high, `flag_en` is high and the engine is idle. A strobe while the engine is busy, or with `flag_en` low, is ignored.
- R2: The frame is driven MSB first, one bit per clock, with `cmd_oe` high for exactly 48 cycles. Its 48 bits are: 0, 1, the index, the argument, the CRC7 (x^7+x^3+1, initial value 0) over the first 40 bits, and a closing 1.
- R3: With `flag_resp` low, the engine sets status bit 3 (sent) at the end bit and returns to idle without waiting for a reply.
- R4: With `flag_pend` high, the engine sends nothing while `pend_in` is low. It stays active and starts the frame after `pend_in` goes high.
- R5: A short reply has the layout 0, 0, index[5:0], payload[31:0], CRC7, 1. On a correct CRC the engine sets status bit 0 (response end), places the payload in `resp_o[31:0]` with the upper bits zero, and places the index in `resp_idx`.
- R6: With `flag_long` set, the engine receives 136 bits. The CRC7 is checked over bits 127:8 against bits 7:1. `resp_o` takes bits 127:0, and `resp_idx` takes bits 133:128. Word k of the response is `resp_o[32k+31:32k]`.
- R7: A reply whose CRC field or end bit is wrong sets status bit 1 (CRC fail) and not status bit 0.
- R8: If no start bit (0) appears within 64 clocks after the command end bit, the engine sets status bit 2 (timeout) and returns to idle.
- R9: With `flag_prog` set, the engine stays active after the command or a good reply until `dat0_i` is high. It then sets status bit 4 (programming done).
- R10: `cmd_active` is high from acceptance until the engine returns to idle, and low after reset.
- R11: Status bits are zero after reset and stay set until cleared. A cycle with `clr_stb` high clears exactly the bits set in `clr_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command-line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| flag_en | input | 1 | Enable; the strobe is ignored without it |
| flag_resp | input | 1 | Wait for a reply |
| flag_long | input | 1 | Reply is 136 bits |
| flag_pend | input | 1 | Hold the frame until `pend_in` |
| flag_prog | input | 1 | Wait for busy release on DAT0 |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| pend_in | input | 1 | External pending input |
| cmd_i | input | 1 | Command line input from the card |
| dat0_i | input | 1 | DAT0 level (low means busy) |
| clr_stb | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| cmd_o | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_active | output | 1 | Transfer in progress |
| resp_o | output | 128 | Captured response words |
| resp_idx | output | 6 | Index field of the reply |
| status | output | 5 | Sticky status bits |

## Verification
On every cycle, assertions check the following:
- the enable gate on the strobe;
- that the pending hold keeps the line undriven;
- that the reply timer never passes its limit;
- that at most one status event fires per cycle;
- that status bits stick until cleared and capture every set event.

The bench scenarios show what cycle-level properties cannot:
- the exact frame bits and CRC7;
- the captured short and long replies;
- the reaction to a corrupted CRC;
- the real timeout against a silent card;
- the busy wait on DAT0.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PEND, S_TX, S_WAIT, S_RX, S_CHECK, S_BUSY
  } cmd_state_e;

  localparam int ST_W         = 5;
  localparam int ST_RESP_END  = 0;
  localparam int ST_CRC_FAIL  = 1;
  localparam int ST_TIMEOUT   = 2;
  localparam int ST_SENT      = 3;
  localparam int ST_PROG_DONE = 4;
endpackage

// File: rtl/sdcmd_crc7.sv
`timescale 1ns/1ps
module sdcmd_crc7 #(
  parameter int W = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = crc[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/sdcmd_status.sv
`timescale 1ns/1ps
module sdcmd_status #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_v;
  assign clr_v = clr_stb ? clr_mask : '0;

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v;
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(q) & ~$past(clr_v) & ~q) == '0));
  assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_v) & ~q) == '0));
endmodule

// File: rtl/sdcmd_engine.sv
`timescale 1ns/1ps
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int CRC_W    = 7,
  parameter int RESP_W   = 128,
  parameter int LONG_LEN = 136,
  parameter int TMO      = 64,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              flag_en,
  input  logic              flag_resp,
  input  logic              flag_long,
  input  logic              flag_pend,
  input  logic              flag_prog,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              pend_in,
  input  logic              cmd_i,
  input  logic              dat0_i,
  input  logic              clr_stb,
  input  logic [ST_W-1:0]   clr_mask,
  output logic              cmd_o,
  output logic              cmd_oe,
  output logic              cmd_active,
  output logic [RESP_W-1:0] resp_o,
  output logic [IDX_W-1:0]  resp_idx,
  output logic [ST_W-1:0]   status
);
  localparam int PAY_LEN   = 2 + IDX_W + ARG_W;
  localparam int CMD_LEN   = PAY_LEN + CRC_W + 1;
  localparam int SHORT_LEN = CMD_LEN;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam int TMO_W     = $clog2(TMO + 1);
  localparam int CS_W      = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] C_PAY        = CNT_W'(PAY_LEN);
  localparam logic [CNT_W-1:0] C_CRC_END    = CNT_W'(PAY_LEN + CRC_W);
  localparam logic [CNT_W-1:0] C_CMD_LAST   = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] C_SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] C_LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] C_LCRC_LO    = CNT_W'(LONG_LEN - RESP_W);
  localparam logic [CNT_W-1:0] C_LCRC_HI    = CNT_W'(LONG_LEN - CRC_W - 1);
  localparam logic [TMO_W-1:0] T_LAST       = TMO_W'(TMO - 1);

  cmd_state_e           state;
  logic                 l_resp, l_long, l_prog;
  logic [PAY_LEN-1:0]   tx_sh;
  logic [LONG_LEN-1:0]  rx_sh;
  logic [CNT_W-1:0]     bcnt;
  logic [TMO_W-1:0]     tmr;
  logic [CRC_W-1:0]     tx_crc, rx_crc;
  logic [CS_W-1:0]      crc_sel;
  logic                 tx_bit, rx_en, crc_ok;
  logic [CNT_W-1:0]     rx_last;
  logic [ST_W-1:0]      set_v;

  // serial CRC generators: one for the outgoing frame, one for the reply
  sdcmd_crc7 #(.W(CRC_W), .POLY(POLY)) u_tx_crc (
    .clk(clk), .rst(rst), .clr(state == S_IDLE || state == S_PEND),
    .en(state == S_TX && bcnt < C_PAY), .din(tx_sh[PAY_LEN-1]), .crc(tx_crc));

  sdcmd_crc7 #(.W(CRC_W), .POLY(POLY)) u_rx_crc (
    .clk(clk), .rst(rst), .clr(state == S_WAIT),
    .en(rx_en), .din(cmd_i), .crc(rx_crc));

  always_comb begin
    crc_sel = CS_W'(C_CRC_END - CNT_W'(1) - bcnt);
    if (bcnt < C_PAY)          tx_bit = tx_sh[PAY_LEN-1];
    else if (bcnt < C_CRC_END) tx_bit = tx_crc[crc_sel];
    else                       tx_bit = 1'b1;
  end

  assign rx_en   = (state == S_RX) &&
                   (l_long ? (bcnt >= C_LCRC_LO && bcnt < C_LCRC_HI) : (bcnt < C_PAY));
  assign rx_last = l_long ? C_LONG_LAST : C_SHORT_LAST;
  assign crc_ok  = (rx_crc == rx_sh[CRC_W:1]) && rx_sh[0];

  always_comb begin
    set_v = '0;
    set_v[ST_SENT]      = (state == S_TX) && (bcnt == C_CMD_LAST) && !l_resp;
    set_v[ST_TIMEOUT]   = (state == S_WAIT) && cmd_i && (tmr == T_LAST);
    set_v[ST_RESP_END]  = (state == S_CHECK) && crc_ok;
    set_v[ST_CRC_FAIL]  = (state == S_CHECK) && !crc_ok;
    set_v[ST_PROG_DONE] = (state == S_BUSY) && dat0_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      l_resp   <= 1'b0;
      l_long   <= 1'b0;
      l_prog   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bcnt     <= '0;
      tmr      <= '0;
      cmd_o    <= 1'b1;
      cmd_oe   <= 1'b0;
      resp_o   <= '0;
      resp_idx <= '0;
    end else begin
      cmd_oe <= (state == S_TX);
      cmd_o  <= (state == S_TX) ? tx_bit : 1'b1;
      case (state)
        S_IDLE: if (start && flag_en) begin
          l_resp <= flag_resp;
          l_long <= flag_long;
          l_prog <= flag_prog;
          tx_sh  <= {2'b01, cmd_idx, cmd_arg};
          bcnt   <= '0;
          state  <= flag_pend ? S_PEND : S_TX;
        end
        S_PEND: if (pend_in) state <= S_TX;
        S_TX: begin
          if (bcnt < C_PAY) tx_sh <= {tx_sh[PAY_LEN-2:0], 1'b0};
          if (bcnt == C_CMD_LAST) begin
            bcnt  <= '0;
            tmr   <= '0;
            state <= l_resp ? S_WAIT : (l_prog ? S_BUSY : S_IDLE);
          end else begin
            bcnt <= bcnt + CNT_W'(1);
          end
        end
        S_WAIT: begin
          if (!cmd_i) begin
            rx_sh <= '0;
            bcnt  <= CNT_W'(1);
            state <= S_RX;
          end else if (tmr == T_LAST) begin
            state <= S_IDLE;
          end else begin
            tmr <= tmr + TMO_W'(1);
          end
        end
        S_RX: begin
          rx_sh <= {rx_sh[LONG_LEN-2:0], cmd_i};
          bcnt  <= bcnt + CNT_W'(1);
          if (bcnt == rx_last) state <= S_CHECK;
        end
        S_CHECK: begin
          if (l_long) begin
            resp_o   <= rx_sh[RESP_W-1:0];
            resp_idx <= rx_sh[LONG_LEN-3 -: IDX_W];
          end else begin
            resp_o   <= RESP_W'(rx_sh[PAY_LEN-1 -: ARG_W]);
            resp_idx <= rx_sh[SHORT_LEN-3 -: IDX_W];
          end
          state <= (crc_ok && l_prog) ? S_BUSY : S_IDLE;
        end
        S_BUSY: if (dat0_i) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_active = (state != S_IDLE);

  sdcmd_status #(.W(ST_W)) u_status (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .q(status));

  assert_en_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !flag_en) |=> (state == S_IDLE));
  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PEND && !pend_in) |=> (state == S_PEND && !cmd_oe));
  assert_tmr_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (tmr < TMO_W'(TMO)));
  assert_one_event_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_v));
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_BUSY && !dat0_i) |=> cmd_active);
endmodule

// File: tb/sdcmd_engine_bench.sv
`timescale 1ns/1ps
module sdcmd_engine_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, flag_en, flag_resp, flag_long, flag_pend, flag_prog;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg;
  logic pend_in, cmd_i, dat0_i, clr_stb;
  logic [4:0] clr_mask;
  logic cmd_o, cmd_oe, cmd_active;
  logic [127:0] resp_o;
  logic [5:0] resp_idx;
  logic [4:0] status;

  sdcmd_engine u_sdcmd_engine (
    .clk(clk), .rst(rst), .start(start), .flag_en(flag_en),
    .flag_resp(flag_resp), .flag_long(flag_long), .flag_pend(flag_pend),
    .flag_prog(flag_prog), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .pend_in(pend_in), .cmd_i(cmd_i), .dat0_i(dat0_i), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .cmd_active(cmd_active), .resp_o(resp_o), .resp_idx(resp_idx),
    .status(status));

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [4:0]   st;
    bit           chk;
    logic [127:0] resp;
    logic [5:0]   ridx;
    logic [23:0]  tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input logic [23:0] tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // monitor: every completed command is compared against the scoreboard
  logic prev_act = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    if (prev_act && !cmd_active) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected completion expected=none");
      end else begin
        e = exp_q.pop_front();
        check(e.tag, 128'(status), 128'(e.st));
        if (e.chk) begin
          check(e.tag, resp_o, e.resp);
          check(e.tag, 128'(resp_idx), 128'(e.ridx));
        end
      end
    end
    prev_act = cmd_active;
  end

  // card side: collect driven frame bits
  logic [47:0] cap = '0;
  int cap_n = 0;
  always @(negedge clk) begin
    if (cmd_oe) begin
      cap = {cap[46:0], cmd_o};
      cap_n++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; failures++;
      $display("FAIL R10 actual=watchdog expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push_exp(input logic [4:0] st, input bit chk, input logic [127:0] resp,
                          input logic [5:0] ridx, input logic [23:0] tag);
    exp_t e;
    e.st = st; e.chk = chk; e.resp = resp; e.ridx = ridx; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input bit r, input bit l, input bit p, input bit g);
    @(negedge clk);
    cap_n = 0;
    cmd_idx = idx; cmd_arg = arg;
    flag_resp = r; flag_long = l; flag_pend = p; flag_prog = g;
    flag_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] pl;
    pl = {2'b01, idx, arg};
    while (cap_n < 48) @(negedge clk);
    check("R2 ", 128'(cap), 128'({pl, crc7(136'(pl), 40), 1'b1}));
  endtask

  task automatic send_resp(input logic [135:0] fr, input int n);
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_i = fr[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  function automatic logic [135:0] short_fr(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [39:0] pl;
    logic [6:0] c;
    pl = {2'b00, idx, arg};
    c = crc7(136'(pl), 40);
    if (bad) c = c ^ 7'h01;
    return 136'({pl, c, 1'b1});
  endfunction

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk);
    clr_stb = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_stb = 1'b0; clr_mask = '0;
  endtask

  initial begin
    logic [119:0] body;
    logic [135:0] lfr;
    rst = 1'b1; start = 0; flag_en = 0; flag_resp = 0; flag_long = 0;
    flag_pend = 0; flag_prog = 0; cmd_idx = '0; cmd_arg = '0;
    pend_in = 0; cmd_i = 1'b1; dat0_i = 1'b1; clr_stb = 0; clr_mask = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R10, R11)
    check("R11", 128'(status), 128'(0));
    check("R10", 128'(cmd_active), 128'(0));
    check("R2 ", 128'({cmd_oe, cmd_o}), 128'(2'b01));

    // R1: strobe without enable is ignored
    @(negedge clk);
    cap_n = 0; flag_en = 1'b0; start = 1'b1; cmd_idx = 6'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 ", 128'(cmd_active), 128'(0));
    check("R1 ", 128'(cap_n), 128'(0));

    // R3: no response expected
    push_exp(5'b01000, 0, '0, '0, "R3 ");
    issue(6'd0, 32'h0000_0000, 0, 0, 0, 0);
    wait_frame(6'd0, 32'h0000_0000);
    @(negedge clk);
    check("R3 ", 128'(cmd_active), 128'(0));
    wait_done();
    // R11: sticky, partial clear
    repeat (10) @(negedge clk);
    check("R11", 128'(status), 128'(5'b01000));
    clear(5'b10111);
    check("R11", 128'(status), 128'(5'b01000));
    clear(5'b01000);
    check("R11", 128'(status), 128'(0));

    // R5: short response with good CRC
    push_exp(5'b00001, 1, {96'b0, 32'hDEAD_BEEF}, 6'd17, "R5 ");
    issue(6'd17, 32'hA5A5_1234, 1, 0, 0, 0);
    wait_frame(6'd17, 32'hA5A5_1234);
    send_resp(short_fr(6'd17, 32'hDEAD_BEEF, 0), 48);
    wait_done();
    clear(5'b11111);
    check("R11", 128'(status), 128'(0));

    // R7: short response with a corrupted CRC
    push_exp(5'b00010, 0, '0, '0, "R7 ");
    issue(6'd13, 32'h0001_0000, 1, 0, 0, 0);
    wait_frame(6'd13, 32'h0001_0000);
    send_resp(short_fr(6'd13, 32'h0000_0900, 1), 48);
    wait_done();
    clear(5'b11111);

    // R6: long response
    body = {$urandom, $urandom, $urandom, $urandom};
    lfr = {8'b0011_1111, body, crc7(136'(body), 120), 1'b1};
    push_exp(5'b00001, 1, lfr[127:0], 6'h3F, "R6 ");
    issue(6'd2, 32'h0, 1, 1, 0, 0);
    wait_frame(6'd2, 32'h0);
    send_resp(lfr, 136);
    wait_done();
    clear(5'b11111);

    // R8: silent card -> timeout
    push_exp(5'b00100, 0, '0, '0, "R8 ");
    issue(6'd8, 32'h0000_01AA, 1, 0, 0, 0);
    wait_frame(6'd8, 32'h0000_01AA);
    repeat (30) @(negedge clk);
    check("R8 ", 128'({cmd_active, status}), 128'(6'b100000));
    wait_done();
    clear(5'b11111);

    // R4 + R1: pending hold-off, second strobe ignored while busy
    pend_in = 1'b0;
    push_exp(5'b01000, 0, '0, '0, "R4 ");
    issue(6'd33, 32'h1357_9BDF, 0, 0, 1, 0);
    repeat (20) @(negedge clk);
    check("R4 ", 128'({cmd_active, cmd_oe}), 128'(2'b10));
    check("R4 ", 128'(cap_n), 128'(0));
    cmd_idx = 6'd5; cmd_arg = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pend_in = 1'b1;
    wait_frame(6'd33, 32'h1357_9BDF);  // R1: first command kept
    wait_done();
    pend_in = 1'b0;
    clear(5'b11111);

    // R9: busy on DAT0 after a good reply
    dat0_i = 1'b0;
    push_exp(5'b10001, 1, {96'b0, 32'h0000_0900}, 6'd24, "R9 ");
    issue(6'd24, 32'h0000_4000, 1, 0, 0, 1);
    wait_frame(6'd24, 32'h0000_4000);
    send_resp(short_fr(6'd24, 32'h0000_0900, 0), 48);
    repeat (10) @(negedge clk);
    check("R9 ", 128'({cmd_active, status}), 128'(6'b100001));
    dat0_i = 1'b1;
    wait_done();
    clear(5'b11111);
    check("R11", 128'(status), 128'(0));

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule